// File: doc/BRIEF.md
# Control-Register Access Gate with Read-Modify-Write

This block sits between an instruction pipeline and a bank of control and status registers. Each request names one of four access kinds (plain read, swap, bit-set, bit-clear), a 12-bit register address, a data operand and the privilege level the hart runs at. In the request cycle the block decides whether the access is allowed and, when it is, returns the register's previous contents. One clock later it issues a single write strobe carrying the merged value.

Legality comes from several sources. The address itself encodes the lowest privilege allowed to touch the register and whether the register is read-only. The floating-point status field gates the three floating-point control registers. Two counter-enable masks gate the user-visible counters. The register bank reports whether the address exists at all. Register storage stays outside the block. The block reads through a combinational read port (`rf_raddr`, `rf_rdata`, `rf_hit`) and writes through a registered write port.

The request side is a valid/ready stream. `req_ready` is held high at all times, so the block never back-pressures and every cycle with `req_valid` high is one accepted access. The response (`resp_fault`, `resp_rdata`) is valid in that same cycle and cannot be stalled. The consumer must take it there.

Top module: `csr_access_gate`

## Requirements
- R1: An access faults when `cur_priv` (0 user, 1 supervisor, 3 machine) is numerically below address bits [9:8].
- R2: When address bits [11:10] are 2'b11 the register is read-only, and any access whose effective write mask is nonzero faults. A read-only access with a zero mask is legal.
- R3: The written value is `(old & ~mask) | (new & mask)`. An access whose mask is zero produces no write strobe.
- R4: Access kind encoding sets the new value and mask as follows. 0 = read: mask zero. 1 = swap: new = operand, mask all ones. 2 = set: new all ones, mask = operand. 3 = clear: new zero, mask = operand.
- R5: Addresses 0x001 (exception flags), 0x002 (rounding mode) and 0x003 (combined) fault when `fs_state` is 0.
- R6: A write to one of those three addresses raises `fs_set_dirty` together with the write strobe, so the status field can move to 3. Write data is cut to the field width: 5 bits at 0x001, 3 bits at 0x002, and 8 bits at 0x003, where the rounding mode sits at [7:5] above the flags at [4:0].
- R7: Counter addresses (bits [11:8] = 0xC and bits [6:5] = 0) use an enable bit indexed by address bits [4:0]. Below machine level that bit must be set in `mcounter_en`. At user level it must also be set in `scounter_en`. Otherwise the access faults.
- R8: An address the register bank does not implement (`rf_hit` low) faults.
- R9: `resp_rdata` carries the old register value on a legal access and zero on a faulting one.
- R10: `resp_fault` and `resp_rdata` are combinational in the request cycle. `wr_en` is high for exactly the one cycle after a legal access with a nonzero mask, and never after a fault.
- R11: `req_ready` is always 1. A cycle without `req_valid` produces neither a fault nor a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Always high; the block never stalls |
| req_kind | input | 2 | Access kind (R4 encoding) |
| req_addr | input | 12 | Register address |
| req_operand | input | W | Data operand |
| cur_priv | input | 2 | Current privilege level |
| fs_state | input | 2 | Floating-point status field |
| mcounter_en | input | 32 | Machine-level counter enables |
| scounter_en | input | 32 | Supervisor-level counter enables |
| rf_raddr | output | 12 | Read port address |
| rf_rdata | input | W | Read port data (old value) |
| rf_hit | input | 1 | Address is implemented |
| resp_fault | output | 1 | Access is illegal |
| resp_rdata | output | W | Old value returned |
| wr_en | output | 1 | Registered write strobe |
| wr_addr | output | 12 | Write address |
| wr_data | output | W | Merged write value |
| fs_set_dirty | output | 1 | Request to mark FP status dirty |

## Verification
The bench targets set and clear with a zero operand. A design that derives the mask from the kind alone would write there, and would also fault on a legal read of a read-only register. The counter gate is tested at each privilege level with only one of the two enable masks set. A design that uses the wrong mask, or gates machine mode, returns the wrong fault. Writes to the floating-point registers check the field truncation and the dirty pulse. Faulting accesses and idle cycles check that no write strobe leaks out and that the read data is forced to zero.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_SWAP  = 2'd1,
    ACC_SET   = 2'd2,
    ACC_CLEAR = 2'd3
  } acc_kind_e;

  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_SUPER = 2'd1;
  localparam logic [1:0] PRIV_MACH  = 2'd3;

  localparam logic [1:0] FS_OFF   = 2'd0;

  localparam int ADDR_W    = 12;
  localparam int CNT_N     = 32;
  localparam int FLAG_W    = 5;
  localparam int RMODE_W   = 3;
  localparam int FPALL_W   = FLAG_W + RMODE_W;

  localparam logic [ADDR_W-1:0] A_FP_FLAGS = 12'h001;
  localparam logic [ADDR_W-1:0] A_FP_RMODE = 12'h002;
  localparam logic [ADDR_W-1:0] A_FP_ALL   = 12'h003;
endpackage

// File: rtl/csr_op_expand.sv
module csr_op_expand
  import csr_gate_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   kind,
  input  logic [W-1:0] operand,
  output logic [W-1:0] new_val,
  output logic [W-1:0] mask,
  output logic         mask_nz
);
  always_comb begin
    new_val = '0;
    mask    = '0;
    unique case (acc_kind_e'(kind))
      ACC_SWAP:  begin new_val = operand; mask = '1;      end
      ACC_SET:   begin new_val = '1;      mask = operand; end
      ACC_CLEAR: begin new_val = '0;      mask = operand; end
      default:   begin new_val = '0;      mask = '0;      end
    endcase
    mask_nz = |mask;
  end
endmodule

// File: rtl/csr_access_check.sv
module csr_access_check
  import csr_gate_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        priv,
  input  logic              mask_nz,
  input  logic [1:0]        fs_state,
  input  logic [CNT_N-1:0]  mcounter_en,
  input  logic [CNT_N-1:0]  scounter_en,
  input  logic              hit,
  output logic              is_fp,
  output logic              fault
);
  localparam int IDX_W = $clog2(CNT_N);

  logic              priv_low, ro_bad, fp_bad, ctr_bad, is_ctr;
  logic [CNT_N-1:0]  ctr_en;
  logic [IDX_W-1:0]  ctr_idx;

  always_comb begin
    priv_low = priv < addr[9:8];
    ro_bad   = (addr[11:10] == 2'b11) && mask_nz;
    is_fp    = (addr == A_FP_FLAGS) || (addr == A_FP_RMODE) || (addr == A_FP_ALL);
    fp_bad   = is_fp && (fs_state == FS_OFF);
    is_ctr   = (addr[11:8] == 4'hC) && (addr[6:5] == 2'b00);
    ctr_idx  = addr[IDX_W-1:0];
    ctr_en   = '1;
    if (priv != PRIV_MACH)  ctr_en = ctr_en & mcounter_en;
    if (priv == PRIV_USER)  ctr_en = ctr_en & scounter_en;
    ctr_bad  = is_ctr && !ctr_en[ctr_idx];
    fault    = priv_low || ro_bad || fp_bad || ctr_bad || !hit;
  end
endmodule

// File: rtl/csr_write_merge.sv
module csr_write_merge
  import csr_gate_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      old_val,
  input  logic [W-1:0]      new_val,
  input  logic [W-1:0]      mask,
  output logic [W-1:0]      merged
);
  localparam logic [W-1:0] KEEP_FLAGS = W'((1 << FLAG_W) - 1);
  localparam logic [W-1:0] KEEP_RMODE = W'((1 << RMODE_W) - 1);
  localparam logic [W-1:0] KEEP_ALL   = W'((1 << FPALL_W) - 1);

  logic [W-1:0] raw;
  always_comb begin
    raw = (old_val & ~mask) | (new_val & mask);
    unique case (addr)
      A_FP_FLAGS: merged = raw & KEEP_FLAGS;
      A_FP_RMODE: merged = raw & KEEP_RMODE;
      A_FP_ALL:   merged = raw & KEEP_ALL;
      default:    merged = raw;
    endcase
  end
endmodule

// File: rtl/csr_access_gate.sv
module csr_access_gate
  import csr_gate_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_kind,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [W-1:0]         req_operand,
  input  logic [1:0]           cur_priv,
  input  logic [1:0]           fs_state,
  input  logic [CNT_N-1:0]     mcounter_en,
  input  logic [CNT_N-1:0]     scounter_en,
  output logic [ADDR_W-1:0]    rf_raddr,
  input  logic [W-1:0]         rf_rdata,
  input  logic                 rf_hit,
  output logic                 resp_fault,
  output logic [W-1:0]         resp_rdata,
  output logic                 wr_en,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [W-1:0]         wr_data,
  output logic                 fs_set_dirty
);
  logic [W-1:0] new_val, mask, merged;
  logic         mask_nz, is_fp, illegal, do_write;

  csr_op_expand #(.W(W)) u_expand (
    .kind(req_kind), .operand(req_operand),
    .new_val(new_val), .mask(mask), .mask_nz(mask_nz)
  );

  csr_access_check u_check (
    .addr(req_addr), .priv(cur_priv), .mask_nz(mask_nz),
    .fs_state(fs_state), .mcounter_en(mcounter_en), .scounter_en(scounter_en),
    .hit(rf_hit), .is_fp(is_fp), .fault(illegal)
  );

  csr_write_merge #(.W(W)) u_merge (
    .addr(req_addr), .old_val(rf_rdata), .new_val(new_val),
    .mask(mask), .merged(merged)
  );

  assign req_ready  = 1'b1;
  assign rf_raddr   = req_addr;
  assign resp_fault = req_valid && illegal;
  assign resp_rdata = (req_valid && !illegal) ? rf_rdata : '0;
  assign do_write   = req_valid && !illegal && mask_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en        <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      fs_set_dirty <= 1'b0;
    end else begin
      wr_en        <= do_write;
      fs_set_dirty <= do_write && is_fp;
      if (do_write) begin
        wr_addr <= req_addr;
        wr_data <= merged;
      end
    end
  end
endmodule

// File: rtl/csr_access_gate_chk.sv
module csr_access_gate_chk
  import csr_gate_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic [W-1:0]      req_operand,
  input logic [1:0]        cur_priv,
  input logic [1:0]        fs_state,
  input logic [W-1:0]      rf_rdata,
  input logic              resp_fault,
  input logic [W-1:0]      resp_rdata,
  input logic              wr_en,
  input logic [W-1:0]      wr_data,
  input logic              fs_set_dirty
);
  logic req_fp;
  assign req_fp = (req_addr == A_FP_FLAGS) || (req_addr == A_FP_RMODE) || (req_addr == A_FP_ALL);

  p_priv_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (cur_priv < req_addr[9:8])) |-> resp_fault);

  p_ro_swap_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[11:10] == 2'b11 && req_kind == ACC_SWAP) |-> resp_fault);

  p_set_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(req_kind == ACC_SET) && !$past(req_fp)) |->
      (wr_data == $past(rf_rdata | req_operand)));

  p_fp_off_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fp && fs_state == FS_OFF) |-> resp_fault);

  p_dirty_with_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fs_set_dirty |-> wr_en);

  p_fault_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> (resp_rdata == '0));

  p_write_after_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(req_valid && !resp_fault && req_kind != ACC_READ));

  p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !wr_en);
endmodule

bind csr_access_gate csr_access_gate_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_addr(req_addr), .req_operand(req_operand), .cur_priv(cur_priv),
  .fs_state(fs_state), .rf_rdata(rf_rdata), .resp_fault(resp_fault),
  .resp_rdata(resp_rdata), .wr_en(wr_en), .wr_data(wr_data),
  .fs_set_dirty(fs_set_dirty)
);

// File: tb/csr_access_gate_bench.sv
module csr_access_gate_bench;
  localparam int W = 32;

  typedef struct {
    bit          we;
    logic [11:0] addr;
    logic [W-1:0] data;
    bit          dirty;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [11:0] req_addr = '0;
  logic [W-1:0] req_operand = '0;
  logic [1:0] cur_priv = 2'd3;
  logic [1:0] fs_state = 2'd0;
  logic [31:0] mcounter_en = '0;
  logic [31:0] scounter_en = '0;
  logic [11:0] rf_raddr;
  logic [W-1:0] rf_rdata = '0;
  logic rf_hit = 1'b0;
  logic resp_fault;
  logic [W-1:0] resp_rdata;
  logic wr_en;
  logic [11:0] wr_addr;
  logic [W-1:0] wr_data;
  logic fs_set_dirty;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  csr_access_gate #(.W(W)) u_csr_access_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_operand(req_operand),
    .cur_priv(cur_priv), .fs_state(fs_state), .mcounter_en(mcounter_en),
    .scounter_en(scounter_en), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_hit(rf_hit), .resp_fault(resp_fault), .resp_rdata(resp_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fs_set_dirty(fs_set_dirty)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit model_fault(input logic [1:0] k, input logic [11:0] a,
      input logic [W-1:0] op, input logic [1:0] p, input logic [1:0] fs,
      input logic [31:0] mc, input logic [31:0] sc, input bit hit);
    logic [W-1:0] m;
    bit f;
    m = (k == 2'd0) ? '0 : (k == 2'd1) ? '1 : op;
    f = !hit;
    if (p < a[9:8]) f = 1;
    if (a[11:10] == 2'b11 && m != 0) f = 1;
    if ((a == 12'h001 || a == 12'h002 || a == 12'h003) && fs == 2'd0) f = 1;
    if (a[11:8] == 4'hC && a[6:5] == 2'b00) begin
      if (p != 2'd3 && !mc[a[4:0]]) f = 1;
      if (p == 2'd0 && !sc[a[4:0]]) f = 1;
    end
    return f;
  endfunction

  task automatic access(input logic [1:0] k, input logic [11:0] a,
      input logic [W-1:0] op, input logic [1:0] p, input logic [1:0] fs,
      input logic [31:0] mc, input logic [31:0] sc, input logic [W-1:0] old,
      input bit hit, input string tag);
    exp_t e;
    logic [W-1:0] m, nv, mg;
    bit f;
    f  = model_fault(k, a, op, p, fs, mc, sc, hit);
    m  = (k == 2'd0) ? '0 : (k == 2'd1) ? '1 : op;
    nv = (k == 2'd1) ? op : (k == 2'd2) ? '1 : '0;
    mg = (old & ~m) | (nv & m);
    if (a == 12'h001) mg = mg & 32'h1F;
    if (a == 12'h002) mg = mg & 32'h07;
    if (a == 12'h003) mg = mg & 32'hFF;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_operand = op;
    cur_priv = p; fs_state = fs; mcounter_en = mc; scounter_en = sc;
    rf_rdata = old; rf_hit = hit;
    #1;
    check(resp_fault == f, {tag, " fault"}, W'(resp_fault), W'(f));
    check(resp_rdata == (f ? '0 : old), {tag, " R9 rdata"}, resp_rdata, f ? '0 : old);
    e.we = !f && (m != 0);
    e.addr = a;
    e.data = mg;
    e.dirty = e.we && (a == 12'h001 || a == 12'h002 || a == 12'h003);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b0; req_kind = 2'd1; req_addr = 12'h340;
    req_operand = 32'hFFFF_FFFF; cur_priv = 2'd3; rf_hit = 1'b1;
    #1;
    check(resp_fault == 1'b0, {tag, " idle fault"}, W'(resp_fault), '0);
    e.we = 0; e.addr = '0; e.data = '0; e.dirty = 0; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(wr_en == e.we, {e.tag, " R10 strobe"}, W'(wr_en), W'(e.we));
        if (e.we) begin
          check(wr_addr == e.addr, {e.tag, " R3 waddr"}, W'(wr_addr), W'(e.addr));
          check(wr_data == e.data, {e.tag, " R3 wdata"}, wr_data, e.data);
        end
        check(fs_set_dirty == e.dirty, {e.tag, " R6 dirty"}, W'(fs_set_dirty), W'(e.dirty));
      end else if (rst_n && wr_en) begin
        check(1'b0, "R10 spurious strobe", W'(wr_en), '0);
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    check(wr_en == 1'b0 && fs_set_dirty == 1'b0, "reset R10 outputs idle", W'(wr_en), '0);
    check(req_ready == 1'b1, "reset R11 ready", W'(req_ready), 1);
    rst_n = 1'b1;
    // R4 / R3 / R9: swap, set, clear at machine level
    access(2'd1, 12'h340, 32'h1234_5678, 2'd3, 2'd0, 0, 0, 32'hAAAA_0000, 1, "R4 swap");
    access(2'd2, 12'h340, 32'h0000_000F, 2'd3, 2'd0, 0, 0, 32'h0000_00F0, 1, "R4 set");
    access(2'd3, 12'h340, 32'h0000_000F, 2'd3, 2'd0, 0, 0, 32'h0000_00FF, 1, "R4 clear");
    access(2'd2, 12'h340, 32'h0, 2'd3, 2'd0, 0, 0, 32'h5555_5555, 1, "R3 set zero mask");
    access(2'd3, 12'h340, 32'h0, 2'd3, 2'd0, 0, 0, 32'h5555_5555, 1, "R3 clear zero mask");
    access(2'd0, 12'h340, 32'hFFFF, 2'd3, 2'd0, 0, 0, 32'h0BAD_F00D, 1, "R3 read");
    // R1 privilege
    access(2'd0, 12'h340, 0, 2'd0, 2'd0, 0, 0, 32'h1, 1, "R1 user on machine reg");
    access(2'd1, 12'h340, 7, 2'd1, 2'd0, 0, 0, 32'h1, 1, "R1 super on machine reg");
    access(2'd1, 12'h140, 7, 2'd1, 2'd0, 0, 0, 32'h1, 1, "R1 super on super reg");
    access(2'd1, 12'h240, 7, 2'd1, 2'd0, 0, 0, 32'h1, 1, "R1 super on level2 reg");
    // R2 read-only
    access(2'd1, 12'hF11, 9, 2'd3, 2'd0, 0, 0, 32'h77, 1, "R2 swap read-only");
    access(2'd2, 12'hF11, 1, 2'd3, 2'd0, 0, 0, 32'h77, 1, "R2 set read-only");
    access(2'd3, 12'hF11, 0, 2'd3, 2'd0, 0, 0, 32'h77, 1, "R2 clear zero on read-only");
    access(2'd0, 12'hF11, 0, 2'd3, 2'd0, 0, 0, 32'h77, 1, "R2 read read-only");
    // R5 / R6 floating point
    access(2'd0, 12'h001, 0, 2'd0, 2'd0, 0, 0, 32'h3, 1, "R5 fp off read");
    access(2'd1, 12'h003, 32'hFFFF, 2'd0, 2'd0, 0, 0, 32'h3, 1, "R5 fp off write");
    access(2'd1, 12'h003, 32'hFFFF, 2'd0, 2'd1, 0, 0, 32'h3, 1, "R6 combined write");
    access(2'd1, 12'h002, 32'hFF, 2'd0, 2'd2, 0, 0, 32'h0, 1, "R6 rmode write");
    access(2'd2, 12'h001, 32'hF0, 2'd0, 2'd3, 0, 0, 32'h01, 1, "R6 flags set");
    access(2'd0, 12'h003, 0, 2'd0, 2'd1, 0, 0, 32'hA5, 1, "R6 combined read");
    // R7 counters
    access(2'd0, 12'hC02, 0, 2'd0, 2'd0, 32'h4, 32'h0, 32'h99, 1, "R7 user no super en");
    access(2'd0, 12'hC02, 0, 2'd0, 2'd0, 32'h4, 32'h4, 32'h99, 1, "R7 user both en");
    access(2'd0, 12'hC01, 0, 2'd1, 2'd0, 32'h0, 32'h2, 32'h99, 1, "R7 super no mach en");
    access(2'd0, 12'hC01, 0, 2'd1, 2'd0, 32'h2, 32'h0, 32'h99, 1, "R7 super mach en");
    access(2'd0, 12'hC9F, 0, 2'd0, 2'd0, 32'h8000_0000, 32'h0, 32'h9, 1, "R7 user high half");
    access(2'd0, 12'hC03, 0, 2'd3, 2'd0, 32'h0, 32'h0, 32'h9, 1, "R7 machine ungated");
    // R8 unknown address
    access(2'd0, 12'h7C5, 0, 2'd3, 2'd0, 0, 0, 32'h9, 0, "R8 no handler");
    access(2'd1, 12'h7C5, 5, 2'd3, 2'd0, 0, 0, 32'h9, 0, "R8 no handler write");
    // R11 idle and back-to-back legal writes
    idle("R11 idle");
    access(2'd1, 12'h341, 32'h10, 2'd3, 2'd0, 0, 0, 32'h0, 1, "R10 back-to-back a");
    access(2'd1, 12'h342, 32'h20, 2'd3, 2'd0, 0, 0, 32'h0, 1, "R10 back-to-back b");
    idle("R11 idle tail");
    idle("R11 idle tail2");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule